// File: doc/BRIEF.md
# Machine-Cycle State and Phase Sequencer

This block turns a single oscillator clock into the timing frame of a machine cycle. It halves the oscillator rate into two phase enables that never overlap, and it steps through six states, each of them lasting two oscillator periods. One full pass over the six states is one machine cycle of twelve oscillator periods. Downstream logic does not decode the state itself. It uses one-clock strobes that mark fixed state/phase slots. One strobe marks the point where an external count pin is sampled. Another marks the point where a fresh count value is loaded. A third is a tick at the end of every machine cycle, for timers that count machine cycles.

Every output is a clock enable in the oscillator domain. The block creates no new clock. The slot each strobe fires in is set by a parameter. The defaults are state 5 phase 2 for sampling, state 3 phase 1 for loading, and state 6 phase 2 for the tick. The tick is the last slot of the cycle.

Top module: `mcycle_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the block in state 1, phase 1 after that edge, with `sample_stb`, `load_stb` and `mc_tick` all low.
- R2: Out of reset, exactly one of `ph1` and `ph2` is high in every cycle. The two alternate on every oscillator clock, and `ph1` is the first half of each state.
- R3: `state_idx` is a binary state number from 1 to 6. It keeps its value across phase 1 and advances by one after phase 2. After phase 2 of state 6 it returns to 1.
- R4: `sample_stb` is high exactly in the cycle of state 5, phase 2.
- R5: `load_stb` is high exactly in the cycle of state 3, phase 1.
- R6: `mc_tick` is high exactly in the cycle of state 6, phase 2, and is followed by state 1, phase 1.
- R7: Out of reset, each of the three strobes fires once in every twelve oscillator clocks. Over any 120 consecutive clocks each fires ten times.
- R8: A reset applied in the middle of a machine cycle suppresses any strobe at that point and restarts the sequence from state 1, phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| state_idx | output | STATE_W (3) | Current state number, 1 to 6 |
| ph1 | output | 1 | Phase 1 enable, first half of a state |
| ph2 | output | 1 | Phase 2 enable, second half of a state |
| sample_stb | output | 1 | One-clock strobe at the pin sample slot (S5P2) |
| load_stb | output | 1 | One-clock strobe at the count load slot (S3P1) |
| mc_tick | output | 1 | One-clock strobe once per machine cycle (S6P2) |

## Verification
Two events share a cycle. The machine-cycle tick fires in the same slot where the state counter wraps from 6 back to 1. The bench runs across several cycle boundaries and checks that the tick appears in S6P2 and that the following clock shows state 1, phase 1. The other overlap is a reset that arrives in the sample slot. The bench asserts reset while `sample_stb` is high and expects that no strobe follows and that the sequence restarts at S1P1 and then S1P2.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } phase_e;

  // Linear slot number inside a machine cycle: two slots per state.
  function automatic int unsigned slot_index(int unsigned st, phase_e ph);
    return (st - 1) * 2 + ((ph == PH_TWO) ? 1 : 0);
  endfunction

  // Successor state with wrap from the last state back to 1.
  function automatic int unsigned state_after(int unsigned st, int unsigned n_states);
    return (st >= n_states) ? 1 : st + 1;
  endfunction

endpackage

// File: rtl/mcyc_phase_div.sv
module mcyc_phase_div
  import mcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   state_end
);

  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_ONE;
    else     ph_q <= (ph_q == PH_ONE) ? PH_TWO : PH_ONE;
  end

  assign phase     = ph_q;
  assign state_end = (ph_q == PH_TWO);

endmodule

// File: rtl/mcyc_state_ring.sv
module mcyc_state_ring
  import mcyc_pkg::*;
#(
  parameter int NUM_STATES = 6,
  parameter int STATE_W    = $clog2(NUM_STATES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  output logic [STATE_W-1:0] state,
  output logic               at_last
);

  logic [STATE_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst)          st_q <= STATE_W'(1);
    else if (advance) st_q <= STATE_W'(state_after(int'(st_q), NUM_STATES));
  end

  assign state   = st_q;
  assign at_last = (int'(st_q) == NUM_STATES);

endmodule

// File: rtl/mcyc_slot_strobe.sv
module mcyc_slot_strobe
  import mcyc_pkg::*;
#(
  parameter int STATE_W  = 3,
  parameter int AT_STATE = 1,
  parameter int AT_PHASE = 0
) (
  input  logic [STATE_W-1:0] state,
  input  phase_e             phase,
  output logic               hit
);

  localparam int unsigned TARGET = slot_index(AT_STATE, (AT_PHASE != 0) ? PH_TWO : PH_ONE);

  assign hit = (slot_index(int'(state), phase) == TARGET);

endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import mcyc_pkg::*;
#(
  parameter int NUM_STATES   = 6,
  parameter int SAMPLE_STATE = 5,
  parameter int SAMPLE_PHASE = 1,
  parameter int LOAD_STATE   = 3,
  parameter int LOAD_PHASE   = 0,
  parameter int STATE_W      = $clog2(NUM_STATES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STATE_W-1:0] state_idx,
  output logic               ph1,
  output logic               ph2,
  output logic               sample_stb,
  output logic               load_stb,
  output logic               mc_tick
);

  localparam int N_STB = 3;
  localparam int STB_STATE [N_STB] = '{SAMPLE_STATE, LOAD_STATE, NUM_STATES};
  localparam int STB_PHASE [N_STB] = '{SAMPLE_PHASE, LOAD_PHASE, 1};

  phase_e             phase;
  logic               state_end;
  logic               at_last;
  logic               cycle_wrap;
  logic [STATE_W-1:0] state;
  logic [N_STB-1:0]   stb;

  mcyc_phase_div u_phase (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .state_end (state_end)
  );

  mcyc_state_ring #(
    .NUM_STATES (NUM_STATES),
    .STATE_W    (STATE_W)
  ) u_ring (
    .clk     (clk),
    .rst     (rst),
    .advance (state_end),
    .state   (state),
    .at_last (at_last)
  );

  // Named event: the last slot of the machine cycle, where the ring wraps.
  assign cycle_wrap = state_end && at_last;

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    mcyc_slot_strobe #(
      .STATE_W  (STATE_W),
      .AT_STATE (STB_STATE[g]),
      .AT_PHASE (STB_PHASE[g])
    ) u_stb (
      .state (state),
      .phase (phase),
      .hit   (stb[g])
    );
  end

  assign state_idx  = state;
  assign ph1        = (phase == PH_ONE);
  assign ph2        = (phase == PH_TWO);
  assign sample_stb = stb[0];
  assign load_stb   = stb[1];
  assign mc_tick    = stb[2];

endmodule

// File: rtl/mcycle_seq_chk.sv
module mcycle_seq_chk #(
  parameter int NUM_STATES   = 6,
  parameter int SAMPLE_STATE = 5,
  parameter int LOAD_STATE   = 3,
  parameter int STATE_W      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [STATE_W-1:0] state_idx,
  input logic               ph1,
  input logic               ph2,
  input logic               sample_stb,
  input logic               load_stb,
  input logic               mc_tick,
  input logic               cycle_wrap
);

  localparam int CYC = 2 * NUM_STATES;
  localparam int GW  = $clog2(CYC + 2);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (state_idx == STATE_W'(1)) && ph1 && !sample_stb && !load_stb && !mc_tick);

  // R2
  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones({ph1, ph2}) == 1);
  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    ph1 |=> ph2);

  // R3
  a_r3_hold_in_p1: assert property (@(posedge clk) disable iff (rst)
    ph1 |=> $stable(state_idx));
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (ph2 && (int'(state_idx) != NUM_STATES)) |=> (state_idx == $past(state_idx) + STATE_W'(1)));
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    cycle_wrap |=> (state_idx == STATE_W'(1)) && ph1);

  // R4: the slot after the sample point is phase 1 of the next state
  a_r4_sample_slot: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> ph1 && (int'(state_idx) == SAMPLE_STATE % NUM_STATES + 1));

  // R5: the slot after the load point is phase 2 of the same state
  a_r5_load_slot: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> ph2 && (int'(state_idx) == LOAD_STATE));

  // R6
  a_r6_tick_at_wrap: assert property (@(posedge clk) disable iff (rst)
    mc_tick |-> cycle_wrap);

  // R7: each strobe recurs after exactly one machine cycle
  logic [2:0] stb_bus;
  assign stb_bus = {mc_tick, load_stb, sample_stb};

  for (genvar g = 0; g < 3; g++) begin : g_gap
    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else if (stb_bus[g]) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q <= GW'(CYC)) begin
        gap_q  <= gap_q + GW'(1);
      end
    end
    a_r7_period: assert property (@(posedge clk) disable iff (rst)
      (stb_bus[g] && seen_q) |-> (gap_q == GW'(CYC)));
    a_r7_no_miss: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> (gap_q <= GW'(CYC)));
  end

endmodule

bind mcycle_seq mcycle_seq_chk #(
  .NUM_STATES   (NUM_STATES),
  .SAMPLE_STATE (SAMPLE_STATE),
  .LOAD_STATE   (LOAD_STATE),
  .STATE_W      (STATE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_idx  (state_idx),
  .ph1        (ph1),
  .ph2        (ph2),
  .sample_stb (sample_stb),
  .load_stb   (load_stb),
  .mc_tick    (mc_tick),
  .cycle_wrap (cycle_wrap)
);

// File: tb/sim_mcycle_seq.sv
module sim_mcycle_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] state_idx;
  logic       ph1, ph2, sample_stb, load_stb, mc_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcycle_seq u0 (
    .clk        (clk),
    .rst        (rst),
    .state_idx  (state_idx),
    .ph1        (ph1),
    .ph2        (ph2),
    .sample_stb (sample_stb),
    .load_stb   (load_stb),
    .mc_tick    (mc_tick)
  );

  // One entry per slot: {state[2:0], ph1, ph2, sample, load, tick}
  localparam logic [7:0] SLOT_VEC [12] = '{
    8'b0011_0000, 8'b0010_1000,
    8'b0101_0000, 8'b0100_1000,
    8'b0111_0010, 8'b0110_1000,
    8'b1001_0000, 8'b1000_1000,
    8'b1011_0000, 8'b1010_1100,
    8'b1101_0000, 8'b1100_1001
  };

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_slot(int k);
    logic [7:0] v;
    v = SLOT_VEC[k % 12];
    check_eq("R3 state", int'(state_idx), int'(v[7:5]));
    check_eq("R2 ph1", int'(ph1), int'(v[4]));
    check_eq("R2 ph2", int'(ph2), int'(v[3]));
    check_eq("R4 sample_stb", int'(sample_stb), int'(v[2]));
    check_eq("R5 load_stb", int'(load_stb), int'(v[1]));
    check_eq("R6 mc_tick", int'(mc_tick), int'(v[0]));
  endtask

  initial begin
    int n_smp, n_ld, n_tk;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 state", int'(state_idx), 1);
    check_eq("R1 ph1", int'(ph1), 1);
    check_eq("R1 strobes", int'({sample_stb, load_stb, mc_tick}), 0);
    rst = 1'b0;

    // Table walk over three machine cycles (R2..R6, wrap at R6)
    for (int k = 0; k < 36; k++) begin
      check_slot(k);
      @(negedge clk);
    end

    // R8: reset in the sample slot
    repeat (9) @(negedge clk);
    check_eq("R8 sample before reset", int'(sample_stb), 1);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R8 state after reset", int'(state_idx), 1);
    check_eq("R8 ph1 after reset", int'(ph1), 1);
    check_eq("R8 strobes after reset", int'({sample_stb, load_stb, mc_tick}), 0);
    rst = 1'b0;
    @(negedge clk);
    check_slot(1);

    // R7: ten of each strobe over 120 clocks
    n_smp = 0; n_ld = 0; n_tk = 0;
    for (int k = 0; k < 120; k++) begin
      n_smp += int'(sample_stb);
      n_ld  += int'(load_stb);
      n_tk  += int'(mc_tick);
      @(negedge clk);
    end
    check_eq("R7 sample count", n_smp, 10);
    check_eq("R7 load count", n_ld, 10);
    check_eq("R7 tick count", n_tk, 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule